// File: doc/BRIEF.md
# Serial Row Select Line Sequencer

This block generates the control bits for one scan line of a multiplexed LED panel. On this panel the row drivers are a chain of shift registers. No binary row address reaches them. Three address lines drive the chain instead:

- the row-shift clock,
- the row blank,
- the serial row data.

For every column position of a line, the sequencer produces these three bits and the latch strobe for the column drivers. It also handles the case where the column index lies beyond the line width.

A single token enters the row chain only during row 0 and is clocked onward at the end of every line. The frame's scan controller steps the row index from the last row back to 0, and that wrap is what re-injects the token once per frame. The column-driver latch is stretched across the last three columns of the line. The scan controller supplies the row index, the column index and the active line width. The sequencer has no notion of colour bit-planes, so every plane of a row gets the same pattern.

Top module: `rowsel_seq`

## Requirements
- R1: When the column index is below width minus 3, or is at or beyond the width, all four outputs (row clock, row blank, row data, column latch) are 0.
- R2: Row data is 1 only while the row index is 0. For any other row it stays 0 on every column.
- R3: With row index 0, row data is 1 on column width minus 2 and stays 1 on column width minus 1.
- R4: Row clock and row blank are both 1 on column width minus 1 of every row, and 0 on every other column.
- R5: The column latch is 1 exactly on columns width minus 3, width minus 2 and width minus 1.
- R6: The output pattern depends only on row index, column index and width. The same inputs always give the same outputs.
- R7: Each output reflects the inputs sampled at the previous rising clock edge. Outputs do not change between edges.
- R8: While reset (active low) is asserted, all outputs are 0.
- R9: The width must be at least 3. A column-index width parameter too small to express a width of 3 stops elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| row_idx | input | ROW_W | Current scan row |
| col_idx | input | COL_W | Current column position within the line |
| line_width | input | COL_W | Number of columns in the line (at least 3) |
| row_clk | output | 1 | Row shift clock line |
| row_blank | output | 1 | Row blank line |
| row_data | output | 1 | Serial row token line |
| col_latch | output | 1 | Column-driver latch strobe |

## Verification
The assertions check each output against the inputs registered one edge earlier. They rely on the line width being held at 3 or more whenever reset is released. The stimulus never drives a width below 3, including across resets. Column indices at and beyond the width are exercised deliberately, because the block must stay quiet there. The column index is allowed to jump, so no assertion depends on columns arriving in sequence.

// File: rtl/rowsel_pkg.sv
package rowsel_pkg;

    typedef struct packed {
        logic clk_a;
        logic blank_b;
        logic data_c;
        logic latch;
    } sel_word_t;

    localparam int unsigned LATCH_SPAN = 3;

endpackage

// File: rtl/rowsel_colwin.sv
module rowsel_colwin #(
    parameter int unsigned COL_W = 8
) (
    input  logic [COL_W-1:0] col,
    input  logic [COL_W-1:0] width,
    output logic             at_last,
    output logic             at_pen,
    output logic             in_latch
);
    localparam int unsigned XW = COL_W + 2;

    logic [XW-1:0] col_x;
    logic [XW-1:0] wid_x;

    always_comb begin
        col_x    = XW'(col);
        wid_x    = XW'(width);
        at_last  = (col_x + XW'(1)) == wid_x;
        at_pen   = (col_x + XW'(2)) == wid_x;
        in_latch = (col_x < wid_x) && ((col_x + XW'(rowsel_pkg::LATCH_SPAN)) >= wid_x);
    end
endmodule

// File: rtl/rowsel_token.sv
module rowsel_token #(
    parameter int unsigned ROW_W = 5
) (
    input  logic [ROW_W-1:0] row,
    input  logic             at_last,
    input  logic             at_pen,
    output logic             data_c
);
    logic first_row;

    always_comb begin
        first_row = (row == '0);
        data_c    = first_row && (at_last || at_pen);
    end
endmodule

// File: rtl/rowsel_seq.sv
module rowsel_seq #(
    parameter int unsigned COL_W = 8,
    parameter int unsigned ROW_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ROW_W-1:0] row_idx,
    input  logic [COL_W-1:0] col_idx,
    input  logic [COL_W-1:0] line_width,
    output logic             row_clk,
    output logic             row_blank,
    output logic             row_data,
    output logic             col_latch
);
    import rowsel_pkg::*;

    localparam int unsigned MAX_WIDTH = (1 << COL_W) - 1;
    localparam int unsigned XW        = COL_W + 2;

    if (MAX_WIDTH < LATCH_SPAN) begin : g_bad_width
        $error("rowsel_seq: COL_W too small for a line of at least 3 columns"); // R9
    end

    logic at_last, at_pen, in_latch, tok_c;
    sel_word_t word_d, word_q;

    rowsel_colwin #(.COL_W(COL_W)) u_win (
        .col      (col_idx),
        .width    (line_width),
        .at_last  (at_last),
        .at_pen   (at_pen),
        .in_latch (in_latch)
    );

    rowsel_token #(.ROW_W(ROW_W)) u_tok (
        .row     (row_idx),
        .at_last (at_last),
        .at_pen  (at_pen),
        .data_c  (tok_c)
    );

    always_comb begin
        word_d         = '0;
        word_d.clk_a   = at_last;
        word_d.blank_b = at_last;
        word_d.data_c  = tok_c;
        word_d.latch   = in_latch;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) word_q <= '0;
        else        word_q <= word_d;
    end

    assign row_clk   = word_q.clk_a;
    assign row_blank = word_q.blank_b;
    assign row_data  = word_q.data_c;
    assign col_latch = word_q.latch;

    AST_WIDTH_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        line_width >= COL_W'(3)); // R9
    AST_DATA_ROW0: assert property (@(posedge clk) disable iff (!rst_n)
        row_data |-> ($past(row_idx) == '0)); // R2
    AST_CLK_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        row_clk |-> (XW'($past(col_idx)) + XW'(1) == XW'($past(line_width)))); // R4
    AST_BLANK_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        row_blank |-> (XW'($past(col_idx)) + XW'(1) == XW'($past(line_width)))); // R4
    AST_LATCH_WIN: assert property (@(posedge clk) disable iff (!rst_n)
        col_latch |-> ((XW'($past(col_idx)) < XW'($past(line_width))) &&
                       (XW'($past(col_idx)) + XW'(3) >= XW'($past(line_width))))); // R5
    AST_QUIET_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        (XW'($past(col_idx)) + XW'(3) < XW'($past(line_width))) |->
        !(row_clk || row_blank || row_data || col_latch)); // R1
    AST_DATA_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        row_data |-> col_latch); // R3
endmodule

// File: tb/sim_rowsel_seq.sv
module sim_rowsel_seq;
    localparam int CLK_PERIOD = 10;
    localparam int COL_W = 8;
    localparam int ROW_W = 5;
    localparam int NV = 14;
    // each entry: row, col, width, expected {clk,blank,data,latch}
    localparam int VEC [NV][4] = '{
        '{0, 0, 16, 4'b0000}, '{0, 12, 16, 4'b0000}, '{0, 13, 16, 4'b0001},
        '{0, 14, 16, 4'b0011}, '{0, 15, 16, 4'b1111}, '{0, 16, 16, 4'b0000},
        '{3, 13, 16, 4'b0001}, '{3, 14, 16, 4'b0001}, '{3, 15, 16, 4'b1101},
        '{31, 63, 64, 4'b1101}, '{0, 63, 64, 4'b1111}, '{0, 200, 64, 4'b0000},
        '{1, 0, 3, 4'b0001}, '{0, 1, 3, 4'b0011}
    };

    logic clk = 0, rst_n = 0;
    logic [ROW_W-1:0] row_idx = '0;
    logic [COL_W-1:0] col_idx = '0;
    logic [COL_W-1:0] line_width = 8'd8;
    logic row_clk, row_blank, row_data, col_latch;
    int errors = 0, checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rowsel_seq #(.COL_W(COL_W), .ROW_W(ROW_W)) u0 (
        .clk(clk), .rst_n(rst_n), .row_idx(row_idx), .col_idx(col_idx),
        .line_width(line_width), .row_clk(row_clk), .row_blank(row_blank),
        .row_data(row_data), .col_latch(col_latch)
    );

    function automatic logic [3:0] model(int r, int c, int w);
        logic a, d, l;
        a = (c == w - 1);
        d = (r == 0) && (c == w - 1 || c == w - 2);
        l = (c < w) && (c >= w - 3);
        return {a, a, d, l};
    endfunction

    function automatic logic [3:0] outs();
        return {row_clk, row_blank, row_data, col_latch};
    endfunction

    task automatic check(string req, logic [3:0] exp);
        checks++;
        if (outs() !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", req, outs(), exp);
        end
    endtask

    task automatic step(int r, int c, int w);
        @(negedge clk);
        row_idx = ROW_W'(r); col_idx = COL_W'(c); line_width = COL_W'(w);
        @(posedge clk); #1;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 100000);
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R8: reset holds outputs low even on an active column
        row_idx = '0; col_idx = 8'd7; line_width = 8'd8;
        repeat (3) @(posedge clk);
        #1 check("R8 reset", 4'b0000);

        @(negedge clk) rst_n = 1;
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][0], VEC[i][1], VEC[i][2]);
            check($sformatf("R1/R2/R3/R4/R5 vec%0d", i), 4'(VEC[i][3]));
        end

        // full line sweeps, token row and ordinary row
        for (int r = 0; r < 3; r++) begin
            for (int c = 0; c < 10; c++) begin
                step(r * 7, c, 10);
                check($sformatf("R1 R3 R4 R5 sweep row%0d col%0d", r * 7, c), model(r * 7, c, 10));
            end
        end

        // R2: every nonzero row keeps data low on the last column
        for (int r = 1; r < 32; r++) begin
            step(r, 9, 10);
            check("R2 no token", 4'b1101);
        end

        // minimum width 3 corner
        step(0, 2, 3);  check("R4 R5 width3 last", 4'b1111);
        step(4, 3, 3);  check("R1 width3 beyond", 4'b0000);

        // R7: outputs hold between edges when inputs change
        step(0, 15, 16);
        @(negedge clk);
        col_idx = 8'd0;
        #1 check("R7 hold before edge", 4'b1111);
        @(posedge clk); #1 check("R7 update after edge", 4'b0000);

        // R6: repeated inputs give identical results
        step(0, 14, 16); check("R6 repeat a", 4'b0011);
        step(0, 14, 16); check("R6 repeat b", 4'b0011);

        // R8: mid-run reset clears an active word
        step(0, 15, 16);
        @(negedge clk) rst_n = 0;
        @(posedge clk); #1 check("R8 mid reset", 4'b0000);
        @(negedge clk) rst_n = 1;
        @(posedge clk); #1 check("R8 resume", 4'b1111);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule